// File: doc/BRIEF.md
# Base-and-Bounds Address Relocation Unit

This block sits on the path from a processor to memory and gives each program partition a movable placement with hardware protection. A base register holds the physical start of the running partition. A bounds register holds the partition's last legal physical address, as an absolute value. Every request carries a program-relative address. The block adds the base to that address and compares the sum with the bounds value. A request that passes goes to memory with its write flag unchanged. A request that fails is dropped, and a sticky protection interrupt is raised.

Supervisor software moves a partition by writing a new start into the base register and a new end into the bounds register. A write issued while the core is in user mode changes nothing and raises the same interrupt. A fault status register records the offending relative address and the cause. The interrupt holds until supervisor software clears it.

Translation is registered, so a result appears one cycle after a request is accepted. Both the processor side and the memory side use valid/ready handshakes, and the unit sustains one request per cycle when memory is not stalling.

Top module: `part_reloc`

## Requirements
- R1: The address forwarded to memory is (base + relative address) mod 2^32. It appears on `mem_addr_o` with `mem_valid_o` high in the cycle after the request is accepted. `mem_wr_o` equals the request's `req_wr_i`.
- R2: An access passes only when the full-precision sum base + relative address has no carry out of bit 31, is at least the base, and is at most the bounds value. The bounds value is inclusive.
- R3: A failing access never raises `mem_valid_o`. In the cycle after acceptance, `irq_o` is high, `flt_addr_o` holds the relative address and `flt_cause_o` is 0 (range).
- R4: `req_ready_o` is high whenever the output stage is empty or `mem_ready_i` is high. A stalled output keeps its address and write flag stable. With `mem_ready_i` high, a new request is accepted on every cycle.
- R5: A write with `cfg_we_i` and `sup_mode_i` both high loads the base register (`cfg_sel_i` = 0) or the bounds register (`cfg_sel_i` = 1). A request accepted in the same cycle uses the old value. Requests from the next cycle on use the new value.
- R6: A register write while `sup_mode_i` is low changes neither register. In the next cycle it raises `irq_o` with `flt_cause_o` = 1 (privilege) and `flt_addr_o` equal to the write data.
- R7: `irq_o` stays high until `flt_clr_i` is asserted together with `sup_mode_i`. A clear requested while `sup_mode_i` is low has no effect.
- R8: While the fault flag is set, later faults leave `flt_addr_o` and `flt_cause_o` unchanged. A fault that arrives in the same cycle as an accepted clear sets the flag again and records its own address and cause.
- R9: After reset, base and bounds are 0, `irq_o` and `mem_valid_o` are low, and only relative address 0 passes.
- R10: If a range fault and a user-mode register write occur in the same cycle while the flag is clear, the range fault is the one recorded (cause 0, its relative address).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_mode_i | input | 1 | High when the processor runs in supervisor mode |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 base, 1 bounds |
| cfg_wdata_i | input | 32 | Register write data |
| flt_clr_i | input | 1 | Fault flag clear, honoured in supervisor mode only |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_addr_i | input | 32 | Program-relative address |
| req_wr_i | input | 1 | Request is a write |
| mem_valid_o | output | 1 | Translated request valid |
| mem_ready_i | input | 1 | Memory accepts the translated request |
| mem_addr_o | output | 32 | Physical address |
| mem_wr_o | output | 1 | Write flag passed through |
| irq_o | output | 1 | Protection interrupt (fault flag) |
| flt_addr_o | output | 32 | Recorded relative address or rejected write data |
| flt_cause_o | output | 1 | 0 range fault, 1 privilege fault |

## Verification
Two pairs of functions can land on the same clock edge. The first pair is a supervisor register write and a request acceptance. The bench issues a base write and a request together and expects the forwarded address to use the old base, then sends a second request that must see the new one. The second pair is a fault clear and a new fault. The bench asserts a supervisor clear in the same cycle as an out-of-range request and expects the interrupt to stay high with the new address and cause. It also pairs a user-mode register write with a range fault and expects the range fault to be the one recorded.

// File: rtl/part_reloc_pkg.sv
package part_reloc_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic {
    SEL_BASE   = 1'b0,
    SEL_BOUNDS = 1'b1
  } cfg_sel_e;

  typedef enum logic {
    CAUSE_RANGE = 1'b0,
    CAUSE_PRIV  = 1'b1
  } flt_cause_e;
endpackage

// File: rtl/part_reloc_rstsync.sv
module part_reloc_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/part_reloc_xlate.sv
module part_reloc_xlate #(
  parameter int AW = part_reloc_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] bounds_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_wr_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_wr_o,
  output logic          acc_fail_o
);
  logic [AW:0]   sum_w;
  logic          carry_w, above_lo_w, below_hi_w, in_range_w, accept_w;
  logic          vld_q, vld_d;
  logic [AW-1:0] addr_q;
  logic          wr_q;

  assign sum_w      = {1'b0, base_i} + {1'b0, req_addr_i};
  assign carry_w    = sum_w[AW];
  assign above_lo_w = sum_w[AW-1:0] >= base_i;
  assign below_hi_w = sum_w[AW-1:0] <= bounds_i;
  assign in_range_w = !carry_w && above_lo_w && below_hi_w;

  assign req_ready_o = !vld_q || mem_ready_i;
  assign accept_w    = req_valid_i && req_ready_o;
  assign acc_fail_o  = accept_w && !in_range_w;

  always_comb begin
    vld_d = vld_q;
    if (accept_w)         vld_d = in_range_w;
    else if (mem_ready_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else if (accept_w) begin
      addr_q <= sum_w[AW-1:0];
      wr_q   <= req_wr_i;
    end
  end

  assign mem_valid_o = vld_q;
  assign mem_addr_o  = addr_q;
  assign mem_wr_o    = wr_q;

  // R1: a passing access is forwarded with base + relative, one cycle later
  a_r1_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o &&
     ({1'b0, base_i} + {1'b0, req_addr_i}) <= {1'b0, bounds_i})
    |=> (mem_valid_o && mem_addr_o == $past(base_i + req_addr_i)
         && mem_wr_o == $past(req_wr_i)));

  // R3: an out-of-range access never reaches memory
  a_r3_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o &&
     ({1'b0, base_i} + {1'b0, req_addr_i}) > {1'b0, bounds_i})
    |=> !mem_valid_o);

  // R4: a stalled output holds steady
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i)
    |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_wr_o)));
endmodule

// File: rtl/part_reloc_regs.sv
module part_reloc_regs #(
  parameter int AW = part_reloc_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_mode_i,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          flt_clr_i,
  input  logic          acc_fail_i,
  input  logic [AW-1:0] acc_addr_i,
  output logic [AW-1:0] base_o,
  output logic [AW-1:0] bounds_o,
  output logic          irq_o,
  output logic [AW-1:0] flt_addr_o,
  output logic          flt_cause_o
);
  import part_reloc_pkg::*;

  logic          base_en, bounds_en, priv_viol, clr_ok, flt_set, rec_en;
  logic          flag_q, flag_d;
  logic [AW-1:0] base_q, bounds_q, faddr_q, faddr_d;
  logic          cause_q, cause_d;

  assign base_en   = cfg_we_i && sup_mode_i && (cfg_sel_e'(cfg_sel_i) == SEL_BASE);
  assign bounds_en = cfg_we_i && sup_mode_i && (cfg_sel_e'(cfg_sel_i) == SEL_BOUNDS);
  assign priv_viol = cfg_we_i && !sup_mode_i;
  assign clr_ok    = flt_clr_i && sup_mode_i;
  assign flt_set   = acc_fail_i || priv_viol;
  assign rec_en    = flt_set && (!flag_q || clr_ok);

  always_comb begin
    flag_d  = flag_q;
    faddr_d = faddr_q;
    cause_d = cause_q;
    if (rec_en) begin
      flag_d  = 1'b1;
      faddr_d = acc_fail_i ? acc_addr_i : cfg_wdata_i;
      cause_d = acc_fail_i ? logic'(CAUSE_RANGE) : logic'(CAUSE_PRIV);
    end else if (clr_ok) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (base_en) base_q <= cfg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bounds_q <= '0;
    else if (bounds_en) bounds_q <= cfg_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      faddr_q <= '0;
      cause_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      faddr_q <= faddr_d;
      cause_q <= cause_d;
    end
  end

  assign base_o      = base_q;
  assign bounds_o    = bounds_q;
  assign irq_o       = flag_q;
  assign flt_addr_o  = faddr_q;
  assign flt_cause_o = cause_q;

  // R6: user-mode writes leave both registers untouched
  a_r6_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !sup_mode_i) |=> ($stable(base_q) && $stable(bounds_q) && irq_o));

  // R7: the interrupt is sticky until a supervisor clear
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(flt_clr_i && sup_mode_i)) |=> irq_o);

  // R8: the first recorded fault is kept while the flag is set
  a_r8_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !(flt_clr_i && sup_mode_i))
    |=> ($stable(flt_addr_o) && $stable(flt_cause_o)));

  // R3: a range fault raises the interrupt one cycle later
  a_r3_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fail_i |=> irq_o);
endmodule

// File: rtl/part_reloc.sv
module part_reloc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sup_mode_i,
  input  logic        cfg_we_i,
  input  logic        cfg_sel_i,
  input  logic [31:0] cfg_wdata_i,
  input  logic        flt_clr_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_addr_i,
  input  logic        req_wr_i,
  output logic        mem_valid_o,
  input  logic        mem_ready_i,
  output logic [31:0] mem_addr_o,
  output logic        mem_wr_o,
  output logic        irq_o,
  output logic [31:0] flt_addr_o,
  output logic        flt_cause_o
);
  localparam int AW = part_reloc_pkg::ADDR_W;

  logic          rst_sync_n;
  logic [AW-1:0] base_w, bounds_w;
  logic          acc_fail_w;

  part_reloc_rstsync #(.STAGES(2)) u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  part_reloc_xlate #(.AW(AW)) u_xlate (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .base_i      (base_w),
    .bounds_i    (bounds_w),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_addr_i  (req_addr_i),
    .req_wr_i    (req_wr_i),
    .mem_valid_o (mem_valid_o),
    .mem_ready_i (mem_ready_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wr_o    (mem_wr_o),
    .acc_fail_o  (acc_fail_w)
  );

  part_reloc_regs #(.AW(AW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .sup_mode_i  (sup_mode_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .flt_clr_i   (flt_clr_i),
    .acc_fail_i  (acc_fail_w),
    .acc_addr_i  (req_addr_i),
    .base_o      (base_w),
    .bounds_o    (bounds_w),
    .irq_o       (irq_o),
    .flt_addr_o  (flt_addr_o),
    .flt_cause_o (flt_cause_o)
  );
endmodule

// File: tb/part_reloc_tb.sv
module part_reloc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        sup_mode_i = 1'b0, cfg_we_i = 1'b0, cfg_sel_i = 1'b0, flt_clr_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0, req_addr_i = '0;
  logic        req_valid_i = 1'b0, req_wr_i = 1'b0, mem_ready_i = 1'b1;
  logic        req_ready_o, mem_valid_o, mem_wr_o, irq_o, flt_cause_o;
  logic [31:0] mem_addr_o, flt_addr_o;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  part_reloc u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg(bit sel, logic [31:0] d, bit sup);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d; sup_mode_i = sup;
    tick();
    cfg_we_i = 1'b0; sup_mode_i = 1'b0;
  endtask

  task automatic send(logic [31:0] rel, bit wr);
    req_valid_i = 1'b1; req_addr_i = rel; req_wr_i = wr;
    tick();
    req_valid_i = 1'b0;
  endtask

  task automatic clear();
    flt_clr_i = 1'b1; sup_mode_i = 1'b1;
    tick();
    flt_clr_i = 1'b0; sup_mode_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 mem_valid after reset", mem_valid_o, 0);
    chk("R9 irq after reset", irq_o, 0);
    chk("R4 ready when empty", req_ready_o, 1);
    send(32'h0, 1'b0);
    chk("R9 rel 0 passes", mem_valid_o, 1);
    chk("R9 rel 0 addr", mem_addr_o, 32'h0);
    send(32'h4, 1'b0);
    chk("R9 rel 4 blocked", mem_valid_o, 0);
    chk("R9 rel 4 irq", irq_o, 1);
    clear();
    chk("R7 supervisor clear", irq_o, 0);
  endtask

  task automatic t_translate();
    cfg(1'b0, 32'h1000, 1'b1);
    cfg(1'b1, 32'h1FFF, 1'b1);
    send(32'h10, 1'b1);
    chk("R1 addr", mem_addr_o, 32'h1010);
    chk("R1 wr flag", mem_wr_o, 1);
    send(32'hFFF, 1'b0);
    chk("R2 inclusive end valid", mem_valid_o, 1);
    chk("R2 inclusive end addr", mem_addr_o, 32'h1FFF);
    chk("R1 rd flag", mem_wr_o, 0);
    send(32'h1000, 1'b1);
    chk("R3 over end blocked", mem_valid_o, 0);
    chk("R3 irq", irq_o, 1);
    chk("R3 flt_addr", flt_addr_o, 32'h1000);
    chk("R3 cause range", flt_cause_o, 0);
    clear();
  endtask

  task automatic t_wrap();
    cfg(1'b0, 32'hFFFF_F000, 1'b1);
    cfg(1'b1, 32'hFFFF_FFFF, 1'b1);
    send(32'hFFF, 1'b0);
    chk("R2 top of space", mem_addr_o, 32'hFFFF_FFFF);
    chk("R2 top valid", mem_valid_o, 1);
    send(32'h1000, 1'b0);
    chk("R2 carry blocked", mem_valid_o, 0);
    chk("R2 carry irq", irq_o, 1);
    clear();
  endtask

  task automatic t_stall();
    cfg(1'b0, 32'h1000, 1'b1);
    cfg(1'b1, 32'h1FFF, 1'b1);
    mem_ready_i = 1'b0;
    send(32'h20, 1'b1);
    chk("R4 stalled valid", mem_valid_o, 1);
    chk("R4 ready low", req_ready_o, 0);
    req_valid_i = 1'b1; req_addr_i = 32'h30; req_wr_i = 1'b0;
    tick();
    chk("R4 held addr", mem_addr_o, 32'h1020);
    chk("R4 held wr", mem_wr_o, 1);
    mem_ready_i = 1'b1;
    tick();
    chk("R4 accept on drain", mem_addr_o, 32'h1030);
    req_addr_i = 32'h40;
    tick();
    chk("R4 back-to-back 1", mem_addr_o, 32'h1040);
    req_addr_i = 32'h50;
    tick();
    chk("R4 back-to-back 2", mem_addr_o, 32'h1050);
    req_valid_i = 1'b0;
    tick();
    chk("R4 drained", mem_valid_o, 0);
  endtask

  task automatic t_same_cycle_write();
    cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 32'h1800; sup_mode_i = 1'b1;
    req_valid_i = 1'b1; req_addr_i = 32'h10; req_wr_i = 1'b0;
    tick();
    cfg_we_i = 1'b0; sup_mode_i = 1'b0; req_valid_i = 1'b0;
    chk("R5 old base same cycle", mem_addr_o, 32'h1010);
    send(32'h10, 1'b0);
    chk("R5 new base next", mem_addr_o, 32'h1810);
  endtask

  task automatic t_user_write();
    cfg(1'b0, 32'h5555, 1'b0);
    chk("R6 irq", irq_o, 1);
    chk("R6 cause priv", flt_cause_o, 1);
    chk("R6 flt_addr data", flt_addr_o, 32'h5555);
    send(32'h10, 1'b0);
    chk("R6 base unchanged", mem_addr_o, 32'h1810);
    cfg(1'b1, 32'h0, 1'b0);
    send(32'h7FF, 1'b0);
    chk("R6 bounds unchanged", mem_valid_o, 1);
  endtask

  task automatic t_sticky();
    flt_clr_i = 1'b1; sup_mode_i = 1'b0;
    tick();
    flt_clr_i = 1'b0;
    chk("R7 user clear ignored", irq_o, 1);
    send(32'h900, 1'b0);
    chk("R8 addr kept", flt_addr_o, 32'h5555);
    chk("R8 cause kept", flt_cause_o, 1);
    flt_clr_i = 1'b1; sup_mode_i = 1'b1;
    req_valid_i = 1'b1; req_addr_i = 32'h900;
    tick();
    flt_clr_i = 1'b0; sup_mode_i = 1'b0; req_valid_i = 1'b0;
    chk("R8 re-set irq", irq_o, 1);
    chk("R8 new addr", flt_addr_o, 32'h900);
    chk("R8 new cause", flt_cause_o, 0);
    clear();
    chk("R7 cleared", irq_o, 0);
  endtask

  task automatic t_priority();
    cfg_we_i = 1'b1; cfg_sel_i = 1'b0; cfg_wdata_i = 32'h77; sup_mode_i = 1'b0;
    req_valid_i = 1'b1; req_addr_i = 32'h1000;
    tick();
    cfg_we_i = 1'b0; req_valid_i = 1'b0;
    chk("R10 irq", irq_o, 1);
    chk("R10 cause range", flt_cause_o, 0);
    chk("R10 addr", flt_addr_o, 32'h1000);
    send(32'h0, 1'b0);
    chk("R10 base kept", mem_addr_o, 32'h1800);
    clear();
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_translate();
    t_wrap();
    t_stall();
    t_same_cycle_write();
    t_user_write();
    t_sticky();
    t_priority();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule